// File: doc/BRIEF.md
# Single-Cycle Unaligned Word Memory

This block is a byte-addressable memory that reads and writes 32-bit words at any byte address in one access cycle. Storage is split into four byte-wide banks, one per byte lane. An access at byte address `a` names a row (`a` with the two low bits dropped) and a byte offset (the two low bits). Each bank picks its own row. Banks below the offset move on to the following row, and the rest stay on the named row. A word that straddles a row boundary is therefore fetched or stored in one pass instead of two.

The returned word is rotated so that the byte at `a` lands in the lowest lane, followed by `a+1`, `a+2` and `a+3` (little-endian, right-justified). Write data and byte enables use the same lane order, counted from the requested address. Reads are synchronous and one cycle late. Every access, write included, returns the four bytes as they stood before that access. The row index wraps from the last row back to row 0.

Top module: `byte_lane_mem`

## Requirements
- R1: While reset is asserted, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_en`=1, and 0 in the cycle after each cycle with `req_en`=0.
- R3: A read at an address whose two low bits are 00 returns, one cycle later, the byte at `a+j` in `rsp_rdata[8j+7:8j]` for j=0..3.
- R4: A read at offset 1, 2 or 3 returns the byte at `a+j` in lane j, completed in a single access cycle with the same one-cycle latency as an aligned read.
- R5: For offset o, exactly the banks numbered below o use row+1, so an aligned access keeps all four banks on one row, and a word crossing a row boundary reads correctly.
- R6: On a write, `req_be[j]`=1 stores `req_wdata[8j+7:8j]` at byte `a+j`. Bytes whose enable is 0 keep their old value.
- R7: Byte addresses past the top of memory wrap to byte 0. An access at the last row with offset o>0 reaches bytes 0..o-1.
- R8: A write returns, one cycle later, the four bytes at `a..a+3` as they were before the write.
- R9: In a cycle after one with `req_en`=0, `rsp_rdata` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_en | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (default 8 bits) |
| req_be | input | LANES | Byte enables relative to `req_addr` |
| req_wdata | input | LANES*8 | Write data, lane j for byte `a+j` |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | LANES*8 | Word at the previous access address, lowest lane first |

## Verification
The hardest case to reach is a word that crosses a row boundary while the two rows hold different, known contents. This case also includes the crossing at the top of memory that wraps to row 0. The bench first fills every row with distinct data through aligned writes. It then aims directed accesses at the last bytes of a row and of the memory, and adds random traffic whose offsets are spread evenly. Partial-enable writes that straddle a boundary are followed by reads at a shifted offset, so every bank's row choice shows up in the data.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  // Lane index arithmetic modulo a power-of-two lane count
  function automatic int lane_wrap(input int base, input int step, input int lanes);
    return (base + step) & (lanes - 1);
  endfunction
endpackage

// File: rtl/bmem_row_gen.sv
module bmem_row_gen #(
  parameter int LANES    = 4,
  parameter int ROW_BITS = 6,
  localparam int OFF_BITS = $clog2(LANES)
) (
  input  logic [ROW_BITS-1:0]             row,
  input  logic [OFF_BITS-1:0]             off,
  output logic [LANES-1:0][ROW_BITS-1:0]  bank_row,
  output logic [LANES-1:0]                plus_one
);
  logic [ROW_BITS-1:0] row_inc;

  // Natural wrap of the row counter at the top of memory
  assign row_inc = row + ROW_BITS'(1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign plus_one[k] = (OFF_BITS'(k) < off);
    assign bank_row[k] = plus_one[k] ? row_inc : row;
  end
endmodule

// File: rtl/bmem_bank.sv
module bmem_bank #(
  parameter int ROW_BITS = 6,
  parameter int BYTE_W   = 8,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [BYTE_W-1:0]   wd,
  output logic [BYTE_W-1:0]   rd
);
  logic [BYTE_W-1:0] store [ROWS];
  logic [BYTE_W-1:0] rd_d;

  // Storage array, no reset
  always_ff @(posedge clk) begin
    if (en && we) store[row] <= wd;
  end

  // Read-before-write: next value comes from the array as it stood
  always_comb begin
    rd_d = rd;
    if (en) rd_d = store[row];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd <= '0;
    else        rd <= rd_d;
  end
endmodule

// File: rtl/bmem_steer.sv
module bmem_steer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFF_BITS = $clog2(LANES)
) (
  input  logic [OFF_BITS-1:0]           off,
  input  logic                          we,
  input  logic [LANES-1:0]              be,
  input  logic [LANES*BYTE_W-1:0]       wdata,
  output logic [LANES-1:0]              bank_we,
  output logic [LANES-1:0][BYTE_W-1:0]  bank_wd
);
  import bmem_pkg::*;

  // Bank k stores request lane (k - off) mod LANES
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      int src;
      src        = lane_wrap(k, LANES - int'(off), LANES);
      bank_we[k] = we & be[src];
      bank_wd[k] = wdata[src*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/bmem_gather.sv
module bmem_gather #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFF_BITS = $clog2(LANES)
) (
  input  logic [OFF_BITS-1:0]           off,
  input  logic [LANES-1:0][BYTE_W-1:0]  bank_rd,
  output logic [LANES*BYTE_W-1:0]       rdata
);
  import bmem_pkg::*;

  // Result lane j comes from bank (off + j) mod LANES
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      rdata[j*BYTE_W +: BYTE_W] = bank_rd[lane_wrap(int'(off), j, LANES)];
    end
  end
endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem #(
  parameter int LANES    = 4,
  parameter int BYTE_W   = 8,
  parameter int ROW_BITS = 6,
  localparam int OFF_BITS = $clog2(LANES),
  localparam int ADDR_W   = ROW_BITS + OFF_BITS,
  localparam int WORD_W   = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [OFF_BITS-1:0] req_off;
  logic [ROW_BITS-1:0] req_row;
  assign req_off = req_addr[OFF_BITS-1:0];
  assign req_row = req_addr[ADDR_W-1:OFF_BITS];

  logic [LANES-1:0][ROW_BITS-1:0] lane_row;
  logic [LANES-1:0]               lane_plus1;
  logic [LANES-1:0]               lane_we;
  logic [LANES-1:0][BYTE_W-1:0]   lane_wd;
  logic [LANES-1:0][BYTE_W-1:0]   lane_rd;

  bmem_row_gen #(.LANES(LANES), .ROW_BITS(ROW_BITS)) u_rows (
    .row      (req_row),
    .off      (req_off),
    .bank_row (lane_row),
    .plus_one (lane_plus1)
  );

  bmem_steer #(.LANES(LANES), .BYTE_W(BYTE_W)) u_steer (
    .off     (req_off),
    .we      (req_we),
    .be      (req_be),
    .wdata   (req_wdata),
    .bank_we (lane_we),
    .bank_wd (lane_wd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    bmem_bank #(.ROW_BITS(ROW_BITS), .BYTE_W(BYTE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (req_en),
      .we    (lane_we[k]),
      .row   (lane_row[k]),
      .wd    (lane_wd[k]),
      .rd    (lane_rd[k])
    );
  end

  // Response state: offset of the last access and the valid flag
  logic [OFF_BITS-1:0] off_q, off_d;
  logic                valid_d;

  always_comb begin
    valid_d = req_en;
    off_d   = off_q;
    if (req_en) off_d = req_off;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      off_q     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      off_q     <= off_d;
      rsp_valid <= valid_d;
    end
  end

  bmem_gather #(.LANES(LANES), .BYTE_W(BYTE_W)) u_gather (
    .off     (off_q),
    .bank_rd (lane_rd),
    .rdata   (rsp_rdata)
  );
endmodule

// File: rtl/bmem_checks.sv
module bmem_checks #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  localparam int OFF_BITS = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_en,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LANES-1:0]  req_be,
  input logic [WORD_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic [LANES-1:0]  plus_one
);
  p_reset_out_r1: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && rsp_rdata == '0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_en |=> rsp_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> !rsp_valid);

  p_aligned_one_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_addr[OFF_BITS-1:0] == '0) |-> (plus_one == '0));

  p_plus_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_en |-> ($countones(plus_one) == int'(req_addr[OFF_BITS-1:0])));

  p_write_then_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_we && $past(req_en && req_we && req_be == '1 && rst_n)
     && req_addr == $past(req_addr)) |=> (rsp_rdata == $past(req_wdata, 2)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_en && $past(rst_n)) |=> $stable(rsp_rdata));
endmodule

bind byte_lane_mem bmem_checks #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_en    (req_en),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .plus_one  (lane_plus1)
);

// File: tb/sim_byte_lane_mem.sv
module sim_byte_lane_mem;
  localparam int LANES = 4, ROW_BITS = 6;
  localparam int ADDR_W = ROW_BITS + 2, WORD_W = 32;
  localparam int DEPTH = (1 << ROW_BITS) * LANES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_en = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LANES-1:0]  req_be = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [WORD_W-1:0] rsp_rdata;

  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [DEPTH];
  logic [WORD_W-1:0] last_rd = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_lane_mem #(.LANES(LANES), .ROW_BITS(ROW_BITS)) u0 (.*);

  function automatic logic [WORD_W-1:0] exp_word(input int a);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < LANES; j++) w[j*8 +: 8] = mdl[(a + j) % DEPTH];
    return w;
  endfunction

  task automatic check(input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, check at the following negedge
  task automatic access(input bit we, input int a, input logic [3:0] be,
                        input logic [WORD_W-1:0] wd, input bit chk, input string req);
    logic [WORD_W-1:0] old;
    old = exp_word(a);
    req_en = 1'b1; req_we = we; req_addr = ADDR_W'(a);
    req_be = be; req_wdata = wd;
    if (we)
      for (int j = 0; j < LANES; j++)
        if (be[j]) mdl[(a + j) % DEPTH] = wd[j*8 +: 8];
    @(negedge clk);
    if (chk) begin
      check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
      check(req, rsp_rdata, old);
    end
    last_rd = rsp_rdata;
    req_en = 1'b0;
  endtask

  task automatic idle_check();
    req_en = 1'b0; req_we = 1'b1; req_be = '1;
    req_wdata = $urandom; req_addr = ADDR_W'($urandom);
    @(negedge clk);
    check("R2 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R9 hold", rsp_rdata, last_rd);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset data", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Fill every row with distinct data (old contents unknown, unchecked)
    for (int r = 0; r < DEPTH / LANES; r++)
      access(1'b1, r * LANES, 4'hF, {8'(4*r+3), 8'(4*r+2), 8'(4*r+1), 8'(4*r)} ^ 32'hA5C3_0F96,
             1'b0, "fill");

    access(1'b0, 8,  4'h0, 0, 1'b1, "R3 aligned read");
    access(1'b0, 9,  4'h0, 0, 1'b1, "R4 offset1 read");
    access(1'b0, 14, 4'h0, 0, 1'b1, "R4 offset2 read");
    access(1'b0, 23, 4'h0, 0, 1'b1, "R5 offset3 row crossing");
    access(1'b0, 0,  4'h0, 0, 1'b1, "R5 aligned single row");
    access(1'b0, DEPTH - 1, 4'h0, 0, 1'b1, "R7 wrap offset3");
    access(1'b0, DEPTH - 2, 4'h0, 0, 1'b1, "R7 wrap offset2");
    idle_check();
    access(1'b1, 30, 4'b0101, 32'h1122_3344, 1'b1, "R8 write returns old");
    access(1'b0, 29, 4'h0, 0, 1'b1, "R6 partial write across rows");
    access(1'b0, 32, 4'h0, 0, 1'b1, "R6 disabled bytes kept");
    access(1'b1, DEPTH - 3, 4'b1110, 32'hDEAD_BEEF, 1'b1, "R8 write at top");
    access(1'b0, DEPTH - 4, 4'h0, 0, 1'b1, "R7 wrapped write top");
    access(1'b0, 0, 4'h0, 0, 1'b1, "R7 wrapped write bottom");
    idle_check();
    // Same-location write immediately followed by read
    access(1'b1, 77, 4'hF, 32'hCAFE_F00D, 1'b1, "R8 old before write");
    access(1'b0, 77, 4'h0, 0, 1'b1, "R6 read back");

    for (int i = 0; i < 600; i++) begin
      int a; bit we; logic [3:0] be;
      a  = int'($urandom % DEPTH);
      we = ($urandom % 3) == 0;
      be = 4'($urandom);
      if (($urandom % 8) == 0) idle_check();
      else access(we, a, be, $urandom, 1'b1,
                  we ? "R8 random write" : ((a % 4) == 0 ? "R3 random read" : "R4 random read"));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule